// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may proceed against a page that has already been located. It combines three independent rights sources: the page protection code, read through a key bit that depends on privilege level; the page's no-execute and guarded bits; and a per-key class mask taken from two 64-bit mask registers, one for data and one for instruction fetch. Each source yields a read/write/execute rights set. The final rights are the bitwise AND of the three. Each source can only remove rights.

The requested access type (load, store or fetch) is compared with the final rights. The block produces a grant flag, a flag that tells a fetch fault from a data fault, and one cause flag per kind of violation, so that the exception logic around it can form its status word. It also handles the case of a fetch from a segment marked no-execute. In that case the fault is reported before any page data is considered. The block is purely combinational and has no state.

Top module: `perm_checker`

## Requirements
- R1: The page protection key is `seg_kp` when `problem_state` is 1 and `seg_ks` when it is 0.
- R2: Rights are encoded as bit 0 read, bit 1 write, bit 2 execute. The protection code is {`pte_pp_hi`, `pte_pp`} (3 bits). With key 0, codes 0, 1 and 2 give read/write/execute, and codes 3 and 6 give read/execute. With key 1, code 0 gives nothing, codes 1, 3 and 6 give read/execute, and code 2 gives read/write/execute.
- R3: Protection codes 4, 5 and 7 give no rights for either key.
- R4: When `pte_noexec` or `pte_guard` is 1, execute is removed and read and write are kept.
- R5: The class-mask field for key k sits at bits [2*(31-k)+1 : 2*(31-k)] of a mask register. When `key_prot_en` is 1, bit 1 of the `amr` field removes write and bit 0 removes read. When `key_prot_en` is 0, `amr` has no effect.
- R6: When both `key_prot_en` and `ext_mode_en` are 1, bit 0 of the `iamr` field removes execute. Bit 1 of that field is ignored. In every other mode `iamr` has no effect.
- R7: `rights` is the AND of the three sources. `acc_type` is encoded 0 load (needs read), 1 store (needs write), 2 fetch (needs execute), 3 no access (needs nothing). `grant` is 1 exactly when the needed right is present, except in the case of R10.
- R8: On a fetch fault, `cause_nxg` is set if the no-execute/guard source removed execute. Otherwise `cause_prot` is set if the protection code lacks execute. `cause_key` is set, independently of the other two, if the instruction mask removed execute.
- R9: On a data fault, `cause_prot` is set if the protection code lacks the needed right, `cause_key` is set if the data mask lacks it, and `cause_store` is set for a store. `cause_nxg` is never set.
- R10: A fetch with `seg_noexec` = 1 is refused with `fetch_fault` and `cause_nxg` only, whatever the page rights are. `seg_noexec` has no effect on loads and stores.
- R11: `fetch_fault` is set only for fetches and `data_fault` only for loads and stores. The two are never set together. Exactly one of them is set when `grant` is 0, and all cause flags are 0 when `grant` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| problem_state | input | 1 | Access is made at user privilege |
| seg_kp | input | 1 | Segment key used at user privilege |
| seg_ks | input | 1 | Segment key used at supervisor privilege |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| pte_pp_hi | input | 1 | Upper bit of the page protection code |
| pte_pp | input | 2 | Lower bits of the page protection code |
| pte_noexec | input | 1 | Page no-execute bit |
| pte_guard | input | 1 | Page guarded bit |
| pte_key | input | KEY_W (5) | Page class key |
| key_prot_en | input | 1 | Class-key protection enabled |
| ext_mode_en | input | 1 | Instruction class mask in force |
| amr | input | 2*2^KEY_W (64) | Data class mask register |
| iamr | input | 2*2^KEY_W (64) | Instruction class mask register |
| acc_type | input | 2 | Requested access: 0 load, 1 store, 2 fetch, 3 none |
| rights | output | 3 | Combined rights {execute, write, read} |
| grant | output | 1 | Access allowed |
| fetch_fault | output | 1 | Refused instruction fetch |
| data_fault | output | 1 | Refused load or store |
| cause_nxg | output | 1 | No-execute or guard violation |
| cause_prot | output | 1 | Page protection violation |
| cause_key | output | 1 | Class-key mask violation |
| cause_store | output | 1 | Refused access was a store |

## Verification
The hardest situation to reach from the ports is a fetch fault where several sources disagree: the guard bit and the instruction mask both remove execute while the protection code also lacks it. Only that combination shows that the no-execute/guard cause takes priority over the protection cause while the key cause is still reported alongside. Random stimulus almost never places a set mask bit at the one field selected by a random key, so directed cases set the exact field bit for chosen keys at both ends of the mask (keys 0, 3 and 31) and stack these with guarded pages and key-1 protection codes. Random cases over all fields then check the remaining combinations against a reference model in the bench.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef logic [2:0] rights_t;

  localparam int RB_R = 0;
  localparam int RB_W = 1;
  localparam int RB_X = 2;

  localparam rights_t RIGHTS_NONE = 3'b000;
  localparam rights_t RIGHTS_RW   = 3'b011;
  localparam rights_t RIGHTS_RX   = 3'b101;
  localparam rights_t RIGHTS_ALL  = 3'b111;

  // Protection code to rights, for the selected key.
  function automatic rights_t pp_table(input logic key, input logic [2:0] code);
    rights_t r;
    r = RIGHTS_NONE;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: r = RIGHTS_ALL;
        3'd3, 3'd6:       r = RIGHTS_RX;
        default:          r = RIGHTS_NONE;
      endcase
    end else begin
      case (code)
        3'd1, 3'd3, 3'd6: r = RIGHTS_RX;
        3'd2:             r = RIGHTS_ALL;
        default:          r = RIGHTS_NONE;
      endcase
    end
    return r;
  endfunction

  // Right needed by an access type.
  function automatic rights_t need_of(input acc_e acc);
    rights_t r;
    case (acc)
      ACC_LOAD:  r = 3'b001;
      ACC_STORE: r = 3'b010;
      ACC_FETCH: r = 3'b100;
      default:   r = 3'b000;
    endcase
    return r;
  endfunction

  // Rights left after the class-key masks.
  function automatic rights_t key_clamp(input logic [1:0] data_fld, input logic fetch_bit,
                                        input logic data_en, input logic fetch_en);
    rights_t r;
    r = RIGHTS_ALL;
    if (data_en) begin
      if (data_fld[1]) r[RB_W] = 1'b0;
      if (data_fld[0]) r[RB_R] = 1'b0;
      if (fetch_en && fetch_bit) r[RB_X] = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/perm_pp_decode.sv
module perm_pp_decode
  import perm_pkg::*;
(
  input  logic       problem_i,
  input  logic       seg_kp_i,
  input  logic       seg_ks_i,
  input  logic       pp_hi_i,
  input  logic [1:0] pp_lo_i,
  output rights_t    rights_o
);

  logic       key_sel;
  logic [2:0] code;

  assign key_sel  = problem_i ? seg_kp_i : seg_ks_i;
  assign code     = {pp_hi_i, pp_lo_i};
  assign rights_o = pp_table(key_sel, code);

endmodule

// File: rtl/perm_key_mask.sv
module perm_key_mask
  import perm_pkg::*;
#(
  parameter  int KEY_W    = 5,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int REG_W    = 2 * NUM_KEYS
) (
  input  logic [REG_W-1:0] amr_i,
  input  logic [REG_W-1:0] iamr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             data_en_i,
  input  logic             fetch_en_i,
  output rights_t          rights_o
);

  logic [1:0]          amr_tab  [NUM_KEYS];
  logic                iamr_tab [NUM_KEYS];
  logic [NUM_KEYS-1:0] iamr_hi_unused;
  logic                unused_iamr_fold;

  // Key k owns the field whose low bit is 2*(NUM_KEYS-1-k): key 0 at the top.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
    localparam int LSB = 2 * (NUM_KEYS - 1 - k);
    assign amr_tab[k]        = amr_i[LSB +: 2];
    assign iamr_tab[k]       = iamr_i[LSB];
    assign iamr_hi_unused[k] = iamr_i[LSB + 1];
  end

  assign unused_iamr_fold = ^iamr_hi_unused;

  logic [1:0] amr_sel;
  logic       iamr_sel;

  assign amr_sel  = amr_tab[key_i];
  assign iamr_sel = iamr_tab[key_i];
  assign rights_o = key_clamp(amr_sel, iamr_sel, data_en_i, fetch_en_i);

endmodule

// File: rtl/perm_fault_encode.sv
module perm_fault_encode
  import perm_pkg::*;
(
  input  acc_e    acc_i,
  input  logic    seg_nx_i,
  input  rights_t pp_rights_i,
  input  rights_t nxg_rights_i,
  input  rights_t key_rights_i,
  output rights_t rights_o,
  output logic    grant_o,
  output logic    fetch_fault_o,
  output logic    data_fault_o,
  output logic    cause_nxg_o,
  output logic    cause_prot_o,
  output logic    cause_key_o,
  output logic    cause_store_o
);

  rights_t need;
  rights_t missing;
  logic    seg_block;

  assign rights_o  = pp_rights_i & nxg_rights_i & key_rights_i;
  assign need      = need_of(acc_i);
  assign missing   = need & ~rights_o;
  assign seg_block = (acc_i == ACC_FETCH) && seg_nx_i;

  always_comb begin
    grant_o       = !seg_block && (missing == RIGHTS_NONE);
    fetch_fault_o = 1'b0;
    data_fault_o  = 1'b0;
    cause_nxg_o   = 1'b0;
    cause_prot_o  = 1'b0;
    cause_key_o   = 1'b0;
    cause_store_o = 1'b0;
    if (seg_block) begin
      fetch_fault_o = 1'b1;
      cause_nxg_o   = 1'b1;
    end else if (missing != RIGHTS_NONE) begin
      if (acc_i == ACC_FETCH) begin
        fetch_fault_o = 1'b1;
        cause_nxg_o   = !nxg_rights_i[RB_X];
        cause_prot_o  = nxg_rights_i[RB_X] && !pp_rights_i[RB_X];
        cause_key_o   = !key_rights_i[RB_X];
      end else begin
        data_fault_o  = 1'b1;
        cause_prot_o  = |(need & ~pp_rights_i);
        cause_key_o   = |(need & ~key_rights_i);
        cause_store_o = (acc_i == ACC_STORE);
      end
    end
  end

endmodule

// File: rtl/perm_checker.sv
module perm_checker
  import perm_pkg::*;
#(
  parameter  int KEY_W    = 5,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int REG_W    = 2 * NUM_KEYS
) (
  input  logic             problem_state,
  input  logic             seg_kp,
  input  logic             seg_ks,
  input  logic             seg_noexec,
  input  logic             pte_pp_hi,
  input  logic [1:0]       pte_pp,
  input  logic             pte_noexec,
  input  logic             pte_guard,
  input  logic [KEY_W-1:0] pte_key,
  input  logic             key_prot_en,
  input  logic             ext_mode_en,
  input  logic [REG_W-1:0] amr,
  input  logic [REG_W-1:0] iamr,
  input  logic [1:0]       acc_type,
  output logic [2:0]       rights,
  output logic             grant,
  output logic             fetch_fault,
  output logic             data_fault,
  output logic             cause_nxg,
  output logic             cause_prot,
  output logic             cause_key,
  output logic             cause_store
);

  rights_t pp_rights;
  rights_t nxg_rights;
  rights_t key_rights;
  acc_e    acc;

  assign acc        = acc_e'(acc_type);
  assign nxg_rights = (pte_noexec || pte_guard) ? RIGHTS_RW : RIGHTS_ALL;

  perm_pp_decode u_pp (
    .problem_i (problem_state),
    .seg_kp_i  (seg_kp),
    .seg_ks_i  (seg_ks),
    .pp_hi_i   (pte_pp_hi),
    .pp_lo_i   (pte_pp),
    .rights_o  (pp_rights)
  );

  perm_key_mask #(.KEY_W(KEY_W)) u_key (
    .amr_i      (amr),
    .iamr_i     (iamr),
    .key_i      (pte_key),
    .data_en_i  (key_prot_en),
    .fetch_en_i (ext_mode_en),
    .rights_o   (key_rights)
  );

  perm_fault_encode u_fault (
    .acc_i         (acc),
    .seg_nx_i      (seg_noexec),
    .pp_rights_i   (pp_rights),
    .nxg_rights_i  (nxg_rights),
    .key_rights_i  (key_rights),
    .rights_o      (rights),
    .grant_o       (grant),
    .fetch_fault_o (fetch_fault),
    .data_fault_o  (data_fault),
    .cause_nxg_o   (cause_nxg),
    .cause_prot_o  (cause_prot),
    .cause_key_o   (cause_key),
    .cause_store_o (cause_store)
  );

endmodule

// File: rtl/perm_checker_sva.sv
module perm_checker_sva (
  input logic       seg_noexec,
  input logic       pte_pp_hi,
  input logic [1:0] pte_pp,
  input logic       pte_noexec,
  input logic       pte_guard,
  input logic       key_prot_en,
  input logic [1:0] acc_type,
  input logic [2:0] rights,
  input logic       grant,
  input logic       fetch_fault,
  input logic       data_fault,
  input logic       cause_nxg,
  input logic       cause_prot,
  input logic       cause_key,
  input logic       cause_store
);

  logic [2:0] need;
  logic       known;

  always_comb begin
    case (acc_type)
      2'd0:    need = 3'b001;
      2'd1:    need = 3'b010;
      2'd2:    need = 3'b100;
      default: need = 3'b000;
    endcase
    known = !$isunknown({seg_noexec, pte_pp_hi, pte_pp, pte_noexec, pte_guard, key_prot_en,
                         acc_type, rights, grant, fetch_fault, data_fault,
                         cause_nxg, cause_prot, cause_key, cause_store});
  end

  always_comb begin
    if (known) begin
      assert_undef_code_R3: assert (!({pte_pp_hi, pte_pp} inside {3'd4, 3'd5, 3'd7}) || rights == 3'b000);
      assert_nxg_strip_R4: assert (!(pte_noexec || pte_guard) || !rights[2]);
      assert_amr_off_R5: assert (key_prot_en || !cause_key);
      assert_grant_R7: assert ((acc_type == 2'd3) || (acc_type == 2'd2 && seg_noexec)
                               || (grant == ((need & ~rights) == 3'b000)));
      assert_no_access_R7: assert (acc_type != 2'd3
                                   || (grant && !cause_nxg && !cause_prot && !cause_key && !cause_store));
      assert_fetch_prio_R8: assert (!(cause_nxg && cause_prot));
      assert_store_flag_R9: assert (!cause_store || (data_fault && acc_type == 2'd1));
      assert_data_nxg_R9: assert (!data_fault || !cause_nxg);
      assert_seg_block_R10: assert (!(acc_type == 2'd2 && seg_noexec)
                                    || (fetch_fault && cause_nxg && !cause_prot && !cause_key && !grant));
      assert_one_kind_R11: assert (!(fetch_fault && data_fault) && ((fetch_fault || data_fault) == !grant));
      assert_kind_match_R11: assert ((!fetch_fault || acc_type == 2'd2)
                                     && (!data_fault || acc_type inside {2'd0, 2'd1}));
    end
  end

endmodule

bind perm_checker perm_checker_sva sva_i (
  .seg_noexec  (seg_noexec),
  .pte_pp_hi   (pte_pp_hi),
  .pte_pp      (pte_pp),
  .pte_noexec  (pte_noexec),
  .pte_guard   (pte_guard),
  .key_prot_en (key_prot_en),
  .acc_type    (acc_type),
  .rights      (rights),
  .grant       (grant),
  .fetch_fault (fetch_fault),
  .data_fault  (data_fault),
  .cause_nxg   (cause_nxg),
  .cause_prot  (cause_prot),
  .cause_key   (cause_key),
  .cause_store (cause_store)
);

// File: tb/perm_checker_tb_top.sv
`timescale 1ns/1ps
module perm_checker_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        problem_state, seg_kp, seg_ks, seg_noexec, pte_pp_hi;
  logic [1:0]  pte_pp;
  logic        pte_noexec, pte_guard;
  logic [4:0]  pte_key;
  logic        key_prot_en, ext_mode_en;
  logic [63:0] amr, iamr;
  logic [1:0]  acc_type;
  logic [2:0]  rights;
  logic        grant, fetch_fault, data_fault, cause_nxg, cause_prot, cause_key, cause_store;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  perm_checker dut_i (
    .problem_state (problem_state), .seg_kp (seg_kp), .seg_ks (seg_ks),
    .seg_noexec (seg_noexec), .pte_pp_hi (pte_pp_hi), .pte_pp (pte_pp),
    .pte_noexec (pte_noexec), .pte_guard (pte_guard), .pte_key (pte_key),
    .key_prot_en (key_prot_en), .ext_mode_en (ext_mode_en),
    .amr (amr), .iamr (iamr), .acc_type (acc_type),
    .rights (rights), .grant (grant), .fetch_fault (fetch_fault),
    .data_fault (data_fault), .cause_nxg (cause_nxg), .cause_prot (cause_prot),
    .cause_key (cause_key), .cause_store (cause_store)
  );

  // Reference: {rights[2:0], grant, fetch_fault, data_fault, nxg, prot, key, store}
  function automatic logic [9:0] model();
    logic       k;
    logic [2:0] pr, xr, kr, fin, nd;
    logic [1:0] fld;
    logic       ib;
    logic       g, ff, df, cn, cp, ck, cs;
    int         sh;
    k  = problem_state ? seg_kp : seg_ks;
    pr = 3'b000;
    case ({pte_pp_hi, pte_pp})
      3'd0: pr = k ? 3'b000 : 3'b111;
      3'd1: pr = k ? 3'b101 : 3'b111;
      3'd2: pr = 3'b111;
      3'd3: pr = 3'b101;
      3'd6: pr = 3'b101;
      default: pr = 3'b000;
    endcase
    xr  = (pte_noexec | pte_guard) ? 3'b011 : 3'b111;
    sh  = 2 * (31 - int'(pte_key));
    fld = 2'((amr >> sh) & 64'd3);
    ib  = iamr[sh];
    kr  = 3'b111;
    if (key_prot_en) begin
      kr[1] = ~fld[1];
      kr[0] = ~fld[0];
      if (ext_mode_en) kr[2] = ~ib;
    end
    fin = pr & xr & kr;
    nd  = (acc_type == 2'd0) ? 3'b001 : (acc_type == 2'd1) ? 3'b010 :
          (acc_type == 2'd2) ? 3'b100 : 3'b000;
    {ff, df, cn, cp, ck, cs} = '0;
    if (acc_type == 2'd2 && seg_noexec) begin
      g = 1'b0; ff = 1'b1; cn = 1'b1;
    end else begin
      g = ((nd & ~fin) == 3'b000);
      if (!g) begin
        if (acc_type == 2'd2) begin
          ff = 1'b1;
          cn = ~xr[2];
          cp = xr[2] & ~pr[2];
          ck = ~kr[2];
        end else begin
          df = 1'b1;
          cp = |(nd & ~pr);
          ck = |(nd & ~kr);
          cs = (acc_type == 2'd1);
        end
      end
    end
    return {fin, g, ff, df, cn, cp, ck, cs};
  endfunction

  task automatic run(input logic prob, input logic kp, input logic ks, input logic snx,
                     input logic [2:0] code, input logic n, input logic g,
                     input logic [4:0] key, input logic kpe, input logic xme,
                     input logic [63:0] a, input logic [63:0] ia,
                     input logic [1:0] acc, input string tag);
    logic [9:0] exp_v, act_v;
    @(negedge clk);
    problem_state = prob; seg_kp = kp; seg_ks = ks; seg_noexec = snx;
    {pte_pp_hi, pte_pp} = code; pte_noexec = n; pte_guard = g; pte_key = key;
    key_prot_en = kpe; ext_mode_en = xme; amr = a; iamr = ia; acc_type = acc;
    #1;
    exp_v = model();
    act_v = {rights, grant, fetch_fault, data_fault, cause_nxg, cause_prot, cause_key, cause_store};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (rights,grant,ff,df,nxg,prot,key,store)",
               tag, act_v, exp_v);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] Z = 64'd0;

  initial begin
    logic [31:0] seed;
    problem_state = 0; seg_kp = 0; seg_ks = 0; seg_noexec = 0; pte_pp_hi = 0; pte_pp = 0;
    pte_noexec = 0; pte_guard = 0; pte_key = 0; key_prot_en = 0; ext_mode_en = 0;
    amr = Z; iamr = Z; acc_type = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Quiet state: all zero inputs, load granted (R7)
    run(0,0,0,0, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd0, "R7 quiet");
    // R1 key selection by privilege
    run(1,1,0,0, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd0, "R1 user uses Kp");
    run(0,1,0,0, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd0, "R1 supervisor uses Ks");
    run(0,0,1,0, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd1, "R1 supervisor Ks set");
    // R2 code table
    run(0,0,1,0, 3'd2, 0,0, 5'd0, 0,0, Z, Z, 2'd1, "R2 key1 code2 store");
    run(0,0,1,0, 3'd1, 0,0, 5'd0, 0,0, Z, Z, 2'd1, "R2 key1 code1 store");
    run(0,0,0,0, 3'd3, 0,0, 5'd0, 0,0, Z, Z, 2'd2, "R2 key0 code3 fetch");
    run(0,0,0,0, 3'd6, 0,0, 5'd0, 0,0, Z, Z, 2'd1, "R2 key0 code6 store");
    // R3 undefined codes
    run(0,0,0,0, 3'd5, 0,0, 5'd0, 0,0, Z, Z, 2'd0, "R3 code5 load");
    run(1,1,0,0, 3'd7, 0,0, 5'd0, 0,0, Z, Z, 2'd2, "R3 code7 fetch");
    run(0,0,0,0, 3'd4, 0,0, 5'd0, 0,0, Z, Z, 2'd1, "R3 code4 store");
    // R4 no-execute / guard
    run(0,0,0,0, 3'd0, 0,1, 5'd0, 0,0, Z, Z, 2'd2, "R4 guard fetch");
    run(0,0,0,0, 3'd0, 1,0, 5'd0, 0,0, Z, Z, 2'd1, "R4 noexec store kept");
    // R5 data class mask
    run(0,0,0,0, 3'd0, 0,0, 5'd0, 1,0, 64'h8000_0000_0000_0000, Z, 2'd1, "R5 key0 write bit store");
    run(0,0,0,0, 3'd0, 0,0, 5'd0, 1,0, 64'h8000_0000_0000_0000, Z, 2'd0, "R5 key0 write bit load");
    run(0,0,0,0, 3'd0, 0,0, 5'd31, 1,0, 64'h1, Z, 2'd0, "R5 key31 read bit");
    run(0,0,0,0, 3'd0, 0,0, 5'd31, 0,0, 64'h1, Z, 2'd0, "R5 mask disabled");
    run(0,0,0,0, 3'd0, 0,0, 5'd30, 1,0, 64'h1, Z, 2'd0, "R5 other key field");
    // R6 instruction class mask
    run(0,0,0,0, 3'd0, 0,0, 5'd3, 1,1, Z, 64'h0100_0000_0000_0000, 2'd2, "R6 key3 exec bit");
    run(0,0,0,0, 3'd0, 0,0, 5'd3, 1,1, Z, 64'h0200_0000_0000_0000, 2'd2, "R6 high bit ignored");
    run(0,0,0,0, 3'd0, 0,0, 5'd3, 1,0, Z, 64'h0100_0000_0000_0000, 2'd2, "R6 ext mode off");
    run(0,0,0,0, 3'd0, 0,0, 5'd3, 0,1, Z, 64'h0100_0000_0000_0000, 2'd2, "R6 key prot off");
    // R8 fetch causes
    run(1,1,0,0, 3'd0, 0,1, 5'd3, 1,1, Z, 64'h0100_0000_0000_0000, 2'd2, "R8 guard+prot+key");
    run(1,1,0,0, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd2, "R8 prot only");
    run(0,0,0,0, 3'd4, 1,0, 5'd0, 0,0, Z, Z, 2'd2, "R8 noexec over prot");
    // R9 data causes
    run(0,0,0,0, 3'd3, 0,0, 5'd0, 1,0, 64'h8000_0000_0000_0000, Z, 2'd1, "R9 store prot+key");
    run(0,0,0,0, 3'd3, 0,0, 5'd0, 1,0, Z, Z, 2'd1, "R9 store prot");
    run(0,0,0,0, 3'd0, 1,1, 5'd31, 1,0, 64'h1, Z, 2'd0, "R9 load key");
    // R10 segment no-execute
    run(0,0,0,1, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd2, "R10 segment fetch");
    run(1,1,0,1, 3'd7, 0,1, 5'd3, 1,1, Z, 64'h0100_0000_0000_0000, 2'd2, "R10 segment over all");
    run(0,0,0,1, 3'd0, 0,0, 5'd0, 0,0, Z, Z, 2'd1, "R10 segment store");
    // R11 no-access request
    run(1,1,0,1, 3'd7, 1,1, 5'd0, 1,1, {64{1'b1}}, {64{1'b1}}, 2'd3, "R11 no access");

    seed = $urandom(32'd20240611);
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  rk;
      logic [63:0] ra, ri;
      rk = 5'($urandom);
      ra = {$urandom, $urandom};
      ri = {$urandom, $urandom};
      if (($urandom % 3) == 0) ra = Z;
      if (($urandom % 3) == 0) ri = Z;
      run(1'($urandom), 1'($urandom), 1'($urandom), (($urandom % 5) == 0),
          3'($urandom), (($urandom % 4) == 0), (($urandom % 4) == 0),
          rk, 1'($urandom), 1'($urandom), ra, ri, 2'($urandom), "R7 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule